// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block stands in front of an on-chip flash array and decides, every cycle, whether a program or erase operation may go ahead. Software drives it through a small register file: a control register with an unlock bit, program and erase mode bits and two verify bits, a read-only status register carrying an error flag, and two 8-bit block mask registers that together cover 16 flash blocks. From these it produces a program enable, one erase enable per block and an encoded current mode for the array's timing logic.

It also watches four system events: a flash read or fetch, exception entry, entry into sleep or a standby mode, and bus release. If one of them arrives while program or erase mode is active, the block latches an error. That error ends the active mode, keeps it from being entered again and still allows the verify modes. Only the asynchronous reset or the hardware standby input clears the error.

Top module: `flash_guard`

## Requirements
- R1: While control bit 0 (unlock) is 0, prog_en_o is 0, blk_erase_en_o is all zero and mode_o is 0 (idle), whatever the other register bits hold.
- R2: Register addresses are 0 control, 1 status, 2 block mask for blocks 7..0 (bit n = block n), 3 block mask for blocks 15..8 (bit n = block 8+n). In erase mode, blk_erase_en_o[k] is 1 only when mask bit k is 1, so with both masks at 0x00 no block is enabled.
- R3: The block masks do not affect programming. prog_en_o is 1 when unlock (bit 0) and program (bit 1) are set and the error flag is clear, whatever the mask values are.
- R4: mode_o encodes 0 idle, 1 program, 2 erase, 3 program-verify (control bit 3), 4 erase-verify (control bit 4). The priority is program, then erase, then program-verify, then erase-verify. Program and erase are only reported while the error flag is clear.
- R5: If flash_rd_i, exc_entry_i, low_pwr_i or bus_rel_i is high at a rising edge while program or erase mode is active (unlock set, bit 1 or bit 2 set, no error), the error flag (status bit 0) reads 1 from the next cycle. The same events outside an active mode leave the flag at 0.
- R6: When the error is taken, prog_en_o and blk_erase_en_o drop in the same cycle as the flag rises. The control and mask registers read back unchanged.
- R7: While the error flag is set, writing the program or erase bit does not enable that mode, but the verify bits still select modes 3 and 4.
- R8: The error flag stays set until rst_ni is low or hw_stby_i is high at a rising edge. hw_stby_i also clears every register to zero, and so does reset.
- R9: A control write with both bit 1 and bit 2 set keeps the previous values of those two bits and stores the other bits.
- R10: Writes to the status address change nothing. Control reads return bits 4..0 with the upper bits zero, and status reads return the flag in bit 0 with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_stby_i | input | 1 | Hardware standby; synchronous clear of all state |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| flash_rd_i | input | 1 | Flash read, vector fetch or instruction fetch event |
| exc_entry_i | input | 1 | Non-reset exception entry event |
| low_pwr_i | input | 1 | Sleep or standby entry event |
| bus_rel_i | input | 1 | Bus release event |
| prog_en_o | output | 1 | Program permitted |
| blk_erase_en_o | output | 16 | Per-block erase permitted |
| mode_o | output | 3 | Current mode code |

## Verification
A register write and an error event can arrive in the same cycle. For example, software may write the program bit, clear it, or switch to erase on the same edge that a flash read or bus release is seen. Whether the error is taken must then depend only on the mode that was active before that edge. The bench provokes this with directed cases and with random cycles in which writes and sparse events overlap freely, and a bench model that updates its state from the pre-edge values judges every output and every register read. A hardware standby that lands together with an event is checked the same way: the standby must win.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam int CTRL_W = 5;
  localparam int NUM_EVT = 4;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_BLK0 = 2;

  typedef enum logic [2:0] {
    MODE_IDLE  = 3'd0,
    MODE_PROG  = 3'd1,
    MODE_ERASE = 3'd2,
    MODE_PVER  = 3'd3,
    MODE_EVER  = 3'd4
  } fg_mode_e;

  typedef struct packed {
    logic ever;
    logic pver;
    logic erase;
    logic prog;
    logic unlock;
  } fg_ctrl_t;
endpackage

// File: rtl/flash_guard_regs.sv
module flash_guard_regs
  import flash_guard_pkg::*;
#(
  parameter int NUM_BLK = 16,
  parameter int BLK_W   = 8,
  parameter int ADDR_W  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [BLK_W-1:0]   wr_data_i,
  output fg_ctrl_t           ctrl_o,
  output logic [NUM_BLK-1:0] blk_mask_o
);
  localparam int NUM_EBR = NUM_BLK / BLK_W;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);

  fg_ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = fg_ctrl_t'(wr_data_i[CTRL_W-1:0]);
    // simultaneous program+erase request keeps the old pair
    if (ctrl_d.prog && ctrl_d.erase) begin
      ctrl_d.prog  = ctrl_q.prog;
      ctrl_d.erase = ctrl_q.erase;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              ctrl_q <= '0;
    else if (clr_i)                           ctrl_q <= '0;
    else if (wr_en_i && wr_addr_i == A_CTRL)  ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  for (genvar g = 0; g < NUM_EBR; g++) begin : g_ebr
    localparam logic [ADDR_W-1:0] A_BLK = ADDR_W'(ADDR_BLK0 + g);
    logic [BLK_W-1:0] ebr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             ebr_q <= '0;
      else if (clr_i)                          ebr_q <= '0;
      else if (wr_en_i && wr_addr_i == A_BLK)  ebr_q <= wr_data_i;
    end
    assign blk_mask_o[g*BLK_W +: BLK_W] = ebr_q;
  end
endmodule

// File: rtl/flash_guard_err.sv
module flash_guard_err
  import flash_guard_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               active_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= 1'b0;
    else if (clr_i) err_q <= 1'b0;
    else            err_q <= err_q | (active_i & (|evt_i));
  end

  assign err_o = err_q;
endmodule

// File: rtl/flash_guard_dec.sv
module flash_guard_dec
  import flash_guard_pkg::*;
#(
  parameter int NUM_BLK = 16
) (
  input  fg_ctrl_t           ctrl_i,
  input  logic               err_i,
  input  logic [NUM_BLK-1:0] blk_mask_i,
  output logic               active_o,
  output logic               prog_en_o,
  output logic [NUM_BLK-1:0] blk_erase_en_o,
  output fg_mode_e           mode_o
);
  logic prog_ok, erase_ok;

  assign prog_ok  = ctrl_i.unlock & ctrl_i.prog  & ~err_i;
  assign erase_ok = ctrl_i.unlock & ctrl_i.erase & ~err_i;
  assign active_o = prog_ok | erase_ok;
  assign prog_en_o = prog_ok;
  assign blk_erase_en_o = erase_ok ? blk_mask_i : '0;

  always_comb begin
    mode_o = MODE_IDLE;
    if (ctrl_i.unlock) begin
      if (prog_ok)          mode_o = MODE_PROG;
      else if (erase_ok)    mode_o = MODE_ERASE;
      else if (ctrl_i.pver) mode_o = MODE_PVER;
      else if (ctrl_i.ever) mode_o = MODE_EVER;
    end
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int NUM_BLK = 16,
  parameter int BLK_W   = 8,
  localparam int NUM_EBR = NUM_BLK / BLK_W,
  localparam int ADDR_W  = $clog2(ADDR_BLK0 + NUM_EBR)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hw_stby_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [BLK_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [BLK_W-1:0]   rd_data_o,
  input  logic               flash_rd_i,
  input  logic               exc_entry_i,
  input  logic               low_pwr_i,
  input  logic               bus_rel_i,
  output logic               prog_en_o,
  output logic [NUM_BLK-1:0] blk_erase_en_o,
  output logic [2:0]         mode_o
);
  fg_ctrl_t           ctrl_q;
  logic [NUM_BLK-1:0] blk_mask;
  logic               err;
  logic               active;
  logic [NUM_EVT-1:0] evt;
  fg_mode_e           mode;

  assign evt = {bus_rel_i, low_pwr_i, exc_entry_i, flash_rd_i};

  flash_guard_regs #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W), .ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni, .clr_i(hw_stby_i), .wr_en_i, .wr_addr_i, .wr_data_i,
    .ctrl_o(ctrl_q), .blk_mask_o(blk_mask)
  );

  flash_guard_err i_err (
    .clk_i, .rst_ni, .clr_i(hw_stby_i), .active_i(active), .evt_i(evt), .err_o(err)
  );

  flash_guard_dec #(.NUM_BLK(NUM_BLK)) i_dec (
    .ctrl_i(ctrl_q), .err_i(err), .blk_mask_i(blk_mask), .active_o(active),
    .prog_en_o, .blk_erase_en_o, .mode_o(mode)
  );

  assign mode_o = mode;

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(ADDR_CTRL))      rd_data_o = BLK_W'(ctrl_q);
    else if (rd_addr_i == ADDR_W'(ADDR_STAT)) rd_data_o = BLK_W'(err);
    else begin
      for (int i = 0; i < NUM_EBR; i++)
        if (rd_addr_i == ADDR_W'(ADDR_BLK0 + i)) rd_data_o = blk_mask[i*BLK_W +: BLK_W];
    end
  end
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
  parameter int NUM_BLK = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               hw_stby_i,
  input logic               unlock_i,
  input logic               err_i,
  input logic               active_i,
  input logic               evt_any_i,
  input logic               prog_en_o,
  input logic [NUM_BLK-1:0] blk_erase_en_o
);
  // R1
  unlock_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlock_i |-> (!prog_en_o && blk_erase_en_o == '0));

  // R4
  prog_erase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prog_en_o && (|blk_erase_en_o)));

  // R5
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && evt_any_i && !hw_stby_i) |=> err_i);

  // R6
  err_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> (!prog_en_o && blk_erase_en_o == '0));

  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !hw_stby_i) |=> err_i);

  // R8
  stby_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_stby_i |=> !err_i);
endmodule

bind flash_guard flash_guard_chk #(.NUM_BLK(NUM_BLK)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hw_stby_i(hw_stby_i),
  .unlock_i(ctrl_q.unlock), .err_i(err), .active_i(active), .evt_any_i(|evt),
  .prog_en_o(prog_en_o), .blk_erase_en_o(blk_erase_en_o)
);

// File: tb/test_flash_guard.sv
module test_flash_guard;
  localparam int CLK_P = 10;
  localparam int NB = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hw_stby_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [1:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       flash_rd_i = 1'b0, exc_entry_i = 1'b0, low_pwr_i = 1'b0, bus_rel_i = 1'b0;
  logic       prog_en_o;
  logic [NB-1:0] blk_erase_en_o;
  logic [2:0] mode_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [4:0]    m_ctrl;
  logic [NB-1:0] m_blk;
  logic          m_err;

  always #(CLK_P/2) clk = ~clk;

  flash_guard i_flash_guard (
    .clk_i(clk), .rst_ni, .hw_stby_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i, .rd_data_o, .flash_rd_i, .exc_entry_i, .low_pwr_i, .bus_rel_i,
    .prog_en_o, .blk_erase_en_o, .mode_o
  );

  function automatic logic f_prog();
    return m_ctrl[0] & m_ctrl[1] & ~m_err;
  endfunction

  function automatic logic [NB-1:0] f_blk();
    return (m_ctrl[0] & m_ctrl[2] & ~m_err) ? m_blk : '0;
  endfunction

  function automatic logic [2:0] f_mode();
    if (!m_ctrl[0]) return 3'd0;
    if (m_ctrl[1] && !m_err) return 3'd1;
    if (m_ctrl[2] && !m_err) return 3'd2;
    if (m_ctrl[3]) return 3'd3;
    if (m_ctrl[4]) return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [7:0] f_rd(input logic [1:0] a);
    case (a)
      2'd0: return {3'b0, m_ctrl};
      2'd1: return {7'b0, m_err};
      2'd2: return m_blk[7:0];
      default: return m_blk[15:8];
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  // one cycle: drive at negedge, model updates with pre-edge state, compare at next negedge
  task automatic step(input logic we, input logic [1:0] wa, input logic [7:0] wd,
                      input logic [3:0] ev, input logic stby, input logic [1:0] ra,
                      input string tag);
    logic act;
    logic [4:0] nd;
    wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    {bus_rel_i, low_pwr_i, exc_entry_i, flash_rd_i} = ev;
    hw_stby_i = stby; rd_addr_i = ra;
    @(posedge clk);
    act = m_ctrl[0] & (m_ctrl[1] | m_ctrl[2]) & ~m_err;
    if (stby) begin
      m_ctrl = '0; m_blk = '0; m_err = 1'b0;
    end else begin
      if (act && (|ev)) m_err = 1'b1;
      if (we) begin
        case (wa)
          2'd0: begin
            nd = wd[4:0];
            if (nd[1] && nd[2]) nd[2:1] = m_ctrl[2:1];
            m_ctrl = nd;
          end
          2'd2: m_blk[7:0] = wd;
          2'd3: m_blk[15:8] = wd;
          default: ;
        endcase
      end
    end
    @(negedge clk);
    chk(tag, "prog_en_o", 32'(prog_en_o), 32'(f_prog()));
    chk(tag, "blk_erase_en_o", 32'(blk_erase_en_o), 32'(f_blk()));
    chk(tag, "mode_o", 32'(mode_o), 32'(f_mode()));
    chk(tag, "rd_data_o", 32'(rd_data_o), 32'(f_rd(ra)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    m_ctrl = '0; m_blk = '0; m_err = 1'b0;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8", "reset prog_en_o", 32'(prog_en_o), 0);
    chk("R8", "reset blk_erase_en_o", 32'(blk_erase_en_o), 0);
    chk("R8", "reset mode_o", 32'(mode_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 erase with masks zero: no block enabled
    step(1, 2'd0, 8'h05, 4'h0, 0, 2'd0, "R2");
    chk("R2", "all masks zero", 32'(blk_erase_en_o), 0);
    step(1, 2'd2, 8'h81, 4'h0, 0, 2'd2, "R2");
    step(1, 2'd3, 8'h40, 4'h0, 0, 2'd3, "R2");
    chk("R2", "block pattern", 32'(blk_erase_en_o), 32'h4081);
    // R1 unlock cleared
    step(1, 2'd0, 8'h04, 4'h0, 0, 2'd0, "R1");
    chk("R1", "locked erase", 32'(blk_erase_en_o), 0);
    step(1, 2'd0, 8'h1A, 4'h0, 0, 2'd0, "R1");
    chk("R1", "locked mode", 32'(mode_o), 0);
    // R3 programming independent of masks
    step(1, 2'd2, 8'h00, 4'h0, 0, 2'd2, "R3");
    step(1, 2'd3, 8'h00, 4'h0, 0, 2'd3, "R3");
    step(1, 2'd0, 8'h03, 4'h0, 0, 2'd0, "R3");
    chk("R3", "prog with zero masks", 32'(prog_en_o), 1);
    // R9 both set keeps program
    step(1, 2'd0, 8'h07, 4'h0, 0, 2'd0, "R9");
    chk("R9", "rd ctrl", 32'(rd_data_o), 32'h03);
    // R4 priority: program wins over verify bits
    step(1, 2'd0, 8'h1B, 4'h0, 0, 2'd0, "R4");
    chk("R4", "prog priority", 32'(mode_o), 1);
    // R10 status write ignored
    step(1, 2'd1, 8'hFF, 4'h0, 0, 2'd1, "R10");
    chk("R10", "status after write", 32'(rd_data_o), 0);
    // R5 flash read while programming, write in same cycle
    step(1, 2'd0, 8'h01, 4'h1, 0, 2'd1, "R5");
    chk("R5", "err after event", 32'(rd_data_o), 1);
    // R6 contents kept
    step(0, 2'd0, 8'h00, 4'h0, 0, 2'd0, "R6");
    chk("R6", "ctrl kept", 32'(rd_data_o), 32'h01);
    // R7 re-enter blocked, verify allowed
    step(1, 2'd0, 8'h03, 4'h0, 0, 2'd1, "R7");
    chk("R7", "prog blocked", 32'(prog_en_o), 0);
    step(1, 2'd0, 8'h09, 4'h0, 0, 2'd0, "R7");
    chk("R7", "pverify", 32'(mode_o), 3);
    step(1, 2'd0, 8'h15, 4'h0, 0, 2'd0, "R7");
    chk("R7", "everify", 32'(mode_o), 4);
    // R8 standby together with event clears
    step(0, 2'd0, 8'h00, 4'h8, 1, 2'd1, "R8");
    chk("R8", "stby clears err", 32'(rd_data_o), 0);
    // R5 events outside active mode
    step(1, 2'd0, 8'h01, 4'hF, 0, 2'd1, "R5");
    step(0, 2'd0, 8'h00, 4'hF, 0, 2'd1, "R5");
    chk("R5", "no err when idle", 32'(rd_data_o), 0);
    // R5 each event source during erase
    for (int e = 0; e < 4; e++) begin
      step(1, 2'd2, 8'hFF, 4'h0, 0, 2'd2, "R5");
      step(1, 2'd0, 8'h05, 4'h0, 0, 2'd0, "R5");
      step(0, 2'd0, 8'h00, 4'(1 << e), 0, 2'd1, "R5");
      chk("R5", "err per source", 32'(rd_data_o), 1);
      chk("R6", "erase dropped", 32'(blk_erase_en_o), 0);
      step(0, 2'd0, 8'h00, 4'h0, 1, 2'd0, "R8");
    end

    // random phase: writes and sparse events overlap
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] ev;
      logic [7:0] d;
      ev = '0;
      for (int b = 0; b < 4; b++) ev[b] = ($urandom % 20) == 0;
      d = 8'($urandom);
      if (($urandom % 3) == 0) d = {3'b0, d[4:1], 1'b1};
      step(($urandom % 2) == 1, 2'($urandom), d, ev, ($urandom % 80) == 0,
           2'($urandom), "RND");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule